// File: doc/BRIEF.md
# CAN Receive Message-Object Buffer

This block holds a bank of receive message objects for a CAN controller. Frames that the bit-level receiver has already decoded (identifier, extended flag, remote flag, length code, eight data bytes) arrive on a one-cycle strobe. Each frame is stored in the lowest-numbered object that is valid, configured for receive and not holding unread data. The store raises that object's new-data and interrupt-pending bits. When every object is occupied, the object marked as the end of the buffer absorbs the frame and records that data was lost.

A host reaches the objects through a small set of 16-bit interface registers. It loads mask, arbitration, control and data words into these registers, chooses which field groups to move with a command mask, and then writes an object number to the command-request register. A transfer controller holds a busy flag for a fixed number of cycles and moves the selected groups on the final one. The transfer goes from the interface registers into the object, or the other way. A read transfer can also clear the object's pending bit. The pending bits of all objects are exported as a vector for an interrupt controller.

The transfer controller has three states. XS_IDLE waits for a request. XS_WAIT counts the transfer latency. XS_MOVE commits the selected groups and returns to XS_IDLE. A valid request moves XS_IDLE to XS_WAIT. When its counter reaches zero, XS_WAIT moves to XS_MOVE. XS_MOVE always returns to XS_IDLE.

Top module: `can_rxbuf`

## Requirements
- R1: After reset the busy flag reads 0, the pending vector is all zeros, and every interface register reads 0.
- R2: A frame strobe stores the frame in the lowest-numbered object that is free. An object is free when its arbitration word has bit 31 (valid) set, bit 29 (direction) clear, and control bit 15 (new data) clear. The store sets control bit 15 and control bit 13 (pending) and writes the length code into control bits 3:0.
- R3: Bit n-1 of the pending vector equals control bit 13 of object n, for objects numbered 1 to 16. The vector also reads back at host address 11.
- R4: When no object is free, the frame overwrites the lowest valid receive object whose control bit 7 (end of buffer) is set. Because that object still holds unread data, the store also sets its control bit 14 (lost).
- R5: A stored standard identifier sits in arbitration bits 28:18, and an extended one in bits 28:0. Bit 30 records the extended flag. Bits 31 and 29 keep their previous values. The arbitration word reads as a low half at address 4 and a high half at address 5.
- R6: A remote frame leaves the object's data bytes unchanged but still updates the identifier, the length code and the status bits.
- R7: The command mask at address 1 selects the direction and the field groups. Bit 7 set means interface-to-object, clear means object-to-interface. Bit 6 selects the mask, bit 5 the arbitration, bit 4 the control word, bit 1 data bytes 0-3 and bit 0 data bytes 4-7. Only the selected groups move. Data byte 2k sits in bits 7:0 of its 16-bit data word (addresses 7 to 10).
- R8: A read transfer with command-mask bit 3 set clears the object's pending bit. The interface control register still receives the value from before the clear.
- R9: Writing an object number from 1 to 16 to address 0 while idle starts a transfer. Bit 15 of address 0 reads 1 for exactly 4 cycles, starting in the cycle after the write. Writes to address 0 and to the interface registers are ignored while busy.
- R10: Writing 0 or a number above 16 to address 0 is ignored and never raises busy.
- R11: If a frame store and the final cycle of a read transfer hit the same object in one cycle, the interface registers get the contents from before the store. The object keeps the stored frame, including a set pending bit, even if the transfer asked to clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fr_valid | input | 1 | One-cycle strobe for a decoded frame |
| fr_id | input | 29 | Frame identifier (bits 10:0 used when standard) |
| fr_xtd | input | 1 | Extended-identifier flag |
| fr_rtr | input | 1 | Remote-frame flag |
| fr_dlc | input | 4 | Data length code |
| fr_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| hst_we | input | 1 | Host register write strobe |
| hst_addr | input | 4 | Host register address |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data (combinational) |
| rx_pend | output | 16 | Pending bit per object, object n at bit n-1 |

## Verification
A frame store and the commit cycle of a host transfer can fall in the same cycle on the same object. The bench provokes this by timing the frame strobe to land on the fourth busy cycle of a read-and-clear transfer aimed at the object that allocation will pick next. It then judges the result from two sides. The interface registers must show the object as it was before the frame. The pending vector and a second read transfer must show the new frame with its pending bit still set.

// File: rtl/can_rxbuf_pkg.sv
package can_rxbuf_pkg;
    localparam int CTL_NEWDAT = 15;
    localparam int CTL_LOST   = 14;
    localparam int CTL_PEND   = 13;
    localparam int CTL_EOB    = 7;
    localparam int ARB_VALID  = 31;
    localparam int ARB_XTD    = 30;
    localparam int ARB_DIR    = 29;
    localparam int CM_WR      = 7;
    localparam int CM_MASK    = 6;
    localparam int CM_ARB     = 5;
    localparam int CM_CTL     = 4;
    localparam int CM_CLRPND  = 3;
    localparam int CM_DATA_A  = 1;
    localparam int CM_DATA_B  = 0;

    localparam logic [3:0] RA_CMDREQ  = 4'd0;
    localparam logic [3:0] RA_CMDMASK = 4'd1;
    localparam logic [3:0] RA_MASK_LO = 4'd2;
    localparam logic [3:0] RA_MASK_HI = 4'd3;
    localparam logic [3:0] RA_ARB_LO  = 4'd4;
    localparam logic [3:0] RA_ARB_HI  = 4'd5;
    localparam logic [3:0] RA_CTL     = 4'd6;
    localparam logic [3:0] RA_DA_LO   = 4'd7;
    localparam logic [3:0] RA_DA_HI   = 4'd8;
    localparam logic [3:0] RA_DB_LO   = 4'd9;
    localparam logic [3:0] RA_DB_HI   = 4'd10;
    localparam logic [3:0] RA_PEND    = 4'd11;

    typedef enum logic [1:0] {XS_IDLE, XS_WAIT, XS_MOVE} xfer_state_e;

    typedef struct packed {
        logic [31:0] mask;
        logic [31:0] arb;
        logic [15:0] ctl;
        logic [63:0] dat;
    } msg_obj_t;
endpackage

// File: rtl/can_rxbuf_alloc.sv
module can_rxbuf_alloc #(
    parameter int NOBJ  = 16,
    parameter int IDX_W = $clog2(NOBJ)
) (
    input  logic [NOBJ-1:0]  free_vec,
    input  logic [NOBJ-1:0]  eob_vec,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    logic             free_hit, eob_hit;
    logic [IDX_W-1:0] free_idx, eob_idx;

    always_comb begin
        free_hit = 1'b0;
        free_idx = '0;
        eob_hit  = 1'b0;
        eob_idx  = '0;
        for (int i = NOBJ - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                free_hit = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (eob_vec[i]) begin
                eob_hit = 1'b1;
                eob_idx = IDX_W'(i);
            end
        end
    end

    assign hit = free_hit | eob_hit;
    assign idx = free_hit ? free_idx : eob_idx;
endmodule

// File: rtl/can_rxbuf_xfer.sv
module can_rxbuf_xfer
    import can_rxbuf_pkg::*;
#(
    parameter int XFER_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic commit
);
    localparam int CNT_W = (XFER_CYC > 2) ? $clog2(XFER_CYC) : 1;

    xfer_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            XS_IDLE: if (start) begin
                state_d = XS_WAIT;
                cnt_d   = CNT_W'(XFER_CYC - 2);
            end
            XS_WAIT: if (cnt_q == '0) state_d = XS_MOVE;
                     else cnt_d = cnt_q - CNT_W'(1);
            XS_MOVE: state_d = XS_IDLE;
            default: state_d = XS_IDLE;
        endcase
    end

    always_comb begin
        busy   = (state_q != XS_IDLE);
        commit = (state_q == XS_MOVE);
    end
endmodule

// File: rtl/can_rxbuf.sv
module can_rxbuf
    import can_rxbuf_pkg::*;
#(
    parameter int NOBJ     = 16,
    parameter int XFER_CYC = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fr_valid,
    input  logic [28:0] fr_id,
    input  logic        fr_xtd,
    input  logic        fr_rtr,
    input  logic [3:0]  fr_dlc,
    input  logic [63:0] fr_data,
    input  logic        hst_we,
    input  logic [3:0]  hst_addr,
    input  logic [15:0] hst_wdata,
    output logic [15:0] hst_rdata,
    output logic [NOBJ-1:0] rx_pend
);
    localparam int IDX_W = $clog2(NOBJ);
    localparam int REQ_W = IDX_W + 2;

    msg_obj_t         obj_q [NOBJ];
    msg_obj_t         store_obj;
    logic [NOBJ-1:0]  free_vec, eob_vec;
    logic             alloc_hit, store_en, req_ok, busy, commit;
    logic [IDX_W-1:0] alloc_idx, sel_idx;
    logic [REQ_W-1:0] if_req, req_m1;
    logic [7:0]       if_cmask;
    logic [31:0]      if_mask, if_arb;
    logic [15:0]      if_ctl;
    logic [63:0]      if_dat;

    for (genvar g = 0; g < NOBJ; g++) begin : g_obj
        assign free_vec[g] = obj_q[g].arb[ARB_VALID] & ~obj_q[g].arb[ARB_DIR]
                           & ~obj_q[g].ctl[CTL_NEWDAT];
        assign eob_vec[g]  = obj_q[g].arb[ARB_VALID] & ~obj_q[g].arb[ARB_DIR]
                           & obj_q[g].ctl[CTL_EOB];
        assign rx_pend[g]  = obj_q[g].ctl[CTL_PEND];
    end

    can_rxbuf_alloc #(.NOBJ(NOBJ), .IDX_W(IDX_W)) u_alloc (
        .free_vec(free_vec), .eob_vec(eob_vec), .hit(alloc_hit), .idx(alloc_idx)
    );

    assign req_ok = hst_we && (hst_addr == RA_CMDREQ) && !busy &&
                    (hst_wdata != 16'd0) && (hst_wdata <= 16'(NOBJ));

    can_rxbuf_xfer #(.XFER_CYC(XFER_CYC)) u_xfer (
        .clk(clk), .rst_n(rst_n), .start(req_ok), .busy(busy), .commit(commit)
    );

    assign req_m1   = if_req - REQ_W'(1);
    assign sel_idx  = req_m1[IDX_W-1:0];
    assign store_en = fr_valid && alloc_hit;

    always_comb begin
        store_obj = obj_q[alloc_idx];
        store_obj.arb[ARB_XTD] = fr_xtd;
        store_obj.arb[28:0]    = fr_xtd ? fr_id : {fr_id[10:0], 18'd0};
        store_obj.ctl[CTL_LOST]   = obj_q[alloc_idx].ctl[CTL_LOST] |
                                    obj_q[alloc_idx].ctl[CTL_NEWDAT];
        store_obj.ctl[CTL_NEWDAT] = 1'b1;
        store_obj.ctl[CTL_PEND]   = 1'b1;
        store_obj.ctl[3:0]        = fr_dlc;
        if (!fr_rtr) store_obj.dat = fr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NOBJ; i++) obj_q[i] <= '0;
        end else begin
            for (int i = 0; i < NOBJ; i++) begin
                if (commit && (sel_idx == IDX_W'(i))) begin
                    if (if_cmask[CM_WR]) begin
                        if (if_cmask[CM_MASK])   obj_q[i].mask       <= if_mask;
                        if (if_cmask[CM_ARB])    obj_q[i].arb        <= if_arb;
                        if (if_cmask[CM_CTL])    obj_q[i].ctl        <= if_ctl;
                        if (if_cmask[CM_DATA_A]) obj_q[i].dat[31:0]  <= if_dat[31:0];
                        if (if_cmask[CM_DATA_B]) obj_q[i].dat[63:32] <= if_dat[63:32];
                    end else if (if_cmask[CM_CLRPND]) begin
                        obj_q[i].ctl[CTL_PEND] <= 1'b0;
                    end
                end
                if (store_en && (alloc_idx == IDX_W'(i))) obj_q[i] <= store_obj;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            if_req <= '0; if_cmask <= '0; if_mask <= '0;
            if_arb <= '0; if_ctl <= '0;   if_dat  <= '0;
        end else if (commit && !if_cmask[CM_WR]) begin
            if (if_cmask[CM_MASK])   if_mask       <= obj_q[sel_idx].mask;
            if (if_cmask[CM_ARB])    if_arb        <= obj_q[sel_idx].arb;
            if (if_cmask[CM_CTL])    if_ctl        <= obj_q[sel_idx].ctl;
            if (if_cmask[CM_DATA_A]) if_dat[31:0]  <= obj_q[sel_idx].dat[31:0];
            if (if_cmask[CM_DATA_B]) if_dat[63:32] <= obj_q[sel_idx].dat[63:32];
        end else if (hst_we && !busy) begin
            case (hst_addr)
                RA_CMDREQ:  if (req_ok) if_req <= hst_wdata[REQ_W-1:0];
                RA_CMDMASK: if_cmask       <= hst_wdata[7:0];
                RA_MASK_LO: if_mask[15:0]  <= hst_wdata;
                RA_MASK_HI: if_mask[31:16] <= hst_wdata;
                RA_ARB_LO:  if_arb[15:0]   <= hst_wdata;
                RA_ARB_HI:  if_arb[31:16]  <= hst_wdata;
                RA_CTL:     if_ctl         <= hst_wdata;
                RA_DA_LO:   if_dat[15:0]   <= hst_wdata;
                RA_DA_HI:   if_dat[31:16]  <= hst_wdata;
                RA_DB_LO:   if_dat[47:32]  <= hst_wdata;
                RA_DB_HI:   if_dat[63:48]  <= hst_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (hst_addr)
            RA_CMDREQ:  hst_rdata = {busy, {(15 - REQ_W){1'b0}}, if_req};
            RA_CMDMASK: hst_rdata = {8'd0, if_cmask};
            RA_MASK_LO: hst_rdata = if_mask[15:0];
            RA_MASK_HI: hst_rdata = if_mask[31:16];
            RA_ARB_LO:  hst_rdata = if_arb[15:0];
            RA_ARB_HI:  hst_rdata = if_arb[31:16];
            RA_CTL:     hst_rdata = if_ctl;
            RA_DA_LO:   hst_rdata = if_dat[15:0];
            RA_DA_HI:   hst_rdata = if_dat[31:16];
            RA_DB_LO:   hst_rdata = if_dat[47:32];
            RA_DB_HI:   hst_rdata = if_dat[63:48];
            RA_PEND:    hst_rdata = 16'(rx_pend);
            default:    hst_rdata = 16'd0;
        endcase
    end
endmodule

// File: rtl/can_rxbuf_chk.sv
module can_rxbuf_chk #(
    parameter int NOBJ = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fr_valid,
    input logic            hst_we,
    input logic [3:0]      hst_addr,
    input logic [15:0]     hst_wdata,
    input logic            busy,
    input logic            commit,
    input logic [NOBJ-1:0] rx_pend
);
    logic [3:0] busy_run;
    logic       req_cyc;

    assign req_cyc = hst_we && (hst_addr == 4'd0) && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     busy_run <= '0;
        else if (busy)  busy_run <= (busy_run == 4'hF) ? busy_run : busy_run + 4'd1;
        else            busy_run <= '0;
    end

    a_r9_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < 4'd6));

    a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_cyc && hst_wdata != 16'd0 && hst_wdata <= 16'(NOBJ)) |=> busy);

    a_r10_bad_number: assert property (@(posedge clk) disable iff (!rst_n)
        (req_cyc && (hst_wdata == 16'd0 || hst_wdata > 16'(NOBJ))) |=> !busy);

    a_r9_commit_ends: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !busy);

    a_r3_pend_source: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_pend & ~$past(rx_pend)) != '0) |-> ($past(fr_valid) || $past(commit)));
endmodule

bind can_rxbuf can_rxbuf_chk #(.NOBJ(NOBJ)) u_chk (
    .clk(clk), .rst_n(rst_n), .fr_valid(fr_valid), .hst_we(hst_we),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .busy(busy),
    .commit(commit), .rx_pend(rx_pend)
);

// File: tb/sim_can_rxbuf.sv
`timescale 1ns/1ps
module sim_can_rxbuf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fr_valid = 1'b0, fr_xtd = 1'b0, fr_rtr = 1'b0;
    logic [28:0] fr_id = '0;
    logic [3:0]  fr_dlc = '0;
    logic [63:0] fr_data = '0;
    logic        hst_we = 1'b0;
    logic [3:0]  hst_addr = '0;
    logic [15:0] hst_wdata = '0;
    logic [15:0] hst_rdata;
    logic [15:0] rx_pend;

    always #2 clk = ~clk;

    can_rxbuf u0 (.*);

    logic [31:0] m_mask [16];
    logic [31:0] m_arb  [16];
    logic [15:0] m_ctl  [16];
    logic [63:0] m_dat  [16];
    logic [31:0] e_mask, e_arb;
    logic [15:0] e_ctl;
    logic [63:0] e_dat;
    int n_chk = 0, n_bad = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); hst_we = 1'b1; hst_addr = a; hst_wdata = d;
        @(negedge clk); hst_we = 1'b0;
    endtask

    task automatic hr(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk); hst_addr = a; #1; d = hst_rdata;
    endtask

    function automatic logic [15:0] m_pend();
        logic [15:0] p;
        for (int i = 0; i < 16; i++) p[i] = m_ctl[i][13];
        return p;
    endfunction

    function automatic int m_alloc();
        for (int i = 0; i < 16; i++)
            if (m_arb[i][31] && !m_arb[i][29] && !m_ctl[i][15]) return i;
        for (int i = 0; i < 16; i++)
            if (m_arb[i][31] && !m_arb[i][29] && m_ctl[i][7]) return i;
        return -1;
    endfunction

    task automatic m_store(input logic [28:0] id, input logic x, input logic r,
                           input logic [3:0] dlc, input logic [63:0] d);
        int k = m_alloc();
        if (k < 0) return;
        m_arb[k] = {m_arb[k][31], x, m_arb[k][29], x ? id : {id[10:0], 18'd0}};
        m_ctl[k][14] = m_ctl[k][14] | m_ctl[k][15];
        m_ctl[k][15] = 1'b1;
        m_ctl[k][13] = 1'b1;
        m_ctl[k][3:0] = dlc;
        if (!r) m_dat[k] = d;
    endtask

    task automatic m_xfer(input int k, input logic [7:0] cm);
        if (cm[7]) begin
            if (cm[6]) m_mask[k] = e_mask;
            if (cm[5]) m_arb[k]  = e_arb;
            if (cm[4]) m_ctl[k]  = e_ctl;
            if (cm[1]) m_dat[k][31:0]  = e_dat[31:0];
            if (cm[0]) m_dat[k][63:32] = e_dat[63:32];
        end else begin
            if (cm[6]) e_mask = m_mask[k];
            if (cm[5]) e_arb  = m_arb[k];
            if (cm[4]) e_ctl  = m_ctl[k];
            if (cm[1]) e_dat[31:0]  = m_dat[k][31:0];
            if (cm[0]) e_dat[63:32] = m_dat[k][63:32];
            if (cm[3]) m_ctl[k][13] = 1'b0;
        end
    endtask

    task automatic drive_frame(input logic [28:0] id, input logic x, input logic r,
                               input logic [3:0] dlc, input logic [63:0] d);
        fr_valid = 1'b1; fr_id = id; fr_xtd = x; fr_rtr = r; fr_dlc = dlc; fr_data = d;
    endtask

    task automatic send(input logic [28:0] id, input logic x, input logic r,
                        input logic [3:0] dlc, input logic [63:0] d);
        @(negedge clk); drive_frame(id, x, r, dlc, d);
        @(negedge clk); fr_valid = 1'b0;
        m_store(id, x, r, dlc, d);
        #1; check("R3 pending vector after frame", rx_pend, m_pend());
    endtask

    task automatic compare_if(input string req);
        logic [15:0] w [9];
        hr(4'd2, w[0]); hr(4'd3, w[1]); hr(4'd4, w[2]); hr(4'd5, w[3]); hr(4'd6, w[4]);
        hr(4'd7, w[5]); hr(4'd8, w[6]); hr(4'd9, w[7]); hr(4'd10, w[8]);
        check({req, " mask"}, {w[1], w[0]}, e_mask);
        check({req, " arb"},  {w[3], w[2]}, e_arb);
        check({req, " ctl"},  w[4], e_ctl);
        check({req, " data"}, {w[8], w[7], w[6], w[5]}, e_dat);
    endtask

    task automatic set_if(input logic [31:0] mk, input logic [31:0] ab,
                          input logic [15:0] ct, input logic [63:0] dt);
        hw(4'd2, mk[15:0]); hw(4'd3, mk[31:16]); hw(4'd4, ab[15:0]); hw(4'd5, ab[31:16]);
        hw(4'd6, ct); hw(4'd7, dt[15:0]); hw(4'd8, dt[31:16]); hw(4'd9, dt[47:32]);
        hw(4'd10, dt[63:48]);
        e_mask = mk; e_arb = ab; e_ctl = ct; e_dat = dt;
    endtask

    task automatic xfer(input int obj, input logic [7:0] cm, input string req);
        int cnt = 0;
        hw(4'd1, {8'd0, cm}); hw(4'd0, 16'(obj));
        hst_addr = 4'd0; #1;
        while (hst_rdata[15] && cnt < 20) begin cnt++; @(negedge clk); #1; end
        check("R9 busy length", cnt, 4);
        m_xfer(obj - 1, cm);
        check({req, " pending"}, rx_pend, m_pend());
        compare_if(req);
    endtask

    task automatic release_obj(input int k);
        logic [15:0] c = m_ctl[k] & 16'h1FFF;
        hw(4'd6, c); e_ctl = c;
        xfer(k + 1, 8'h90, "R7 release");
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        int k, cnt;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 16; i++) begin
            m_mask[i] = '0; m_arb[i] = '0; m_ctl[i] = '0; m_dat[i] = '0;
        end
        e_mask = '0; e_arb = '0; e_ctl = '0; e_dat = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int a = 0; a < 12; a++) begin
            hr(4'(a), d);
            check("R1 reset register", d, 16'd0);
        end
        check("R1 reset pending", rx_pend, 16'd0);

        for (int i = 1; i <= 16; i++) begin
            set_if(32'h0, 32'h8000_0000, (i == 16) ? 16'h0080 : 16'h0000, 64'h0);
            xfer(i, 8'hB0, "R7 configure");
        end

        send(29'h5A3, 1'b0, 1'b0, 4'd8, 64'h8877_6655_4433_2211);
        xfer(1, 8'h33, "R2 standard store");
        check("R5 standard arb high", e_arb[31:16], 16'h968C);
        check("R2 ctl flags", e_ctl, 16'hA008);
        send(29'h1ABC_DEF1, 1'b1, 1'b0, 4'd3, 64'h0102_0304_0506_0708);
        xfer(2, 8'h23, "R5 extended store");
        check("R5 extended arb", e_arb, {3'b110, 29'h1ABC_DEF1});
        send(29'h123, 1'b0, 1'b1, 4'd5, 64'hFFFF_FFFF_FFFF_FFFF);
        xfer(3, 8'h33, "R6 remote keeps data");
        check("R6 remote data", e_dat, 64'h0);
        xfer(2, 8'h18, "R8 clear pending");
        check("R8 pending bit cleared", rx_pend[1], 1'b0);
        check("R8 ctl shows pre-clear", e_ctl[13], 1'b1);

        hw(4'd0, 16'd0); hst_addr = 4'd0; #1;
        check("R10 object 0 no busy", hst_rdata[15], 1'b0);
        hw(4'd0, 16'd17); hst_addr = 4'd0; #1;
        check("R10 object 17 no busy", hst_rdata[15], 1'b0);

        hw(4'd1, 16'h0012); hw(4'd0, 16'd1);
        hw(4'd6, 16'h1234); hw(4'd0, 16'd5);
        hst_addr = 4'd0; #1; cnt = 0;
        while (hst_rdata[15] && cnt < 20) begin cnt++; @(negedge clk); #1; end
        check("R9 request held while busy", hst_rdata[5:0], 6'd1);
        m_xfer(0, 8'h12);
        compare_if("R9 writes ignored while busy");

        for (int i = 0; i < 16; i++) if (m_ctl[i][15]) release_obj(i);
        for (int i = 0; i < 17; i++) send(29'(100 + i), 1'b0, 1'b0, 4'd1, 64'(i));
        xfer(16, 8'h1B, "R4 overwrite end object");
        check("R4 lost flag", e_ctl[14], 1'b1);
        check("R4 last data", e_dat[31:0], 32'd16);
        for (int i = 0; i < 16; i++) release_obj(i);

        k = m_alloc();
        hw(4'd1, 16'h001A); hw(4'd0, 16'(k + 1));
        repeat (3) @(negedge clk);
        drive_frame(29'h7AA, 1'b0, 1'b0, 4'd2, 64'hCAFE);
        @(negedge clk); fr_valid = 1'b0;
        m_xfer(k, 8'h1A);
        m_store(29'h7AA, 1'b0, 1'b0, 4'd2, 64'hCAFE);
        #1; check("R11 pending kept", rx_pend[k], 1'b1);
        compare_if("R11 interface pre-store");
        xfer(k + 1, 8'h33, "R11 object holds frame");

        for (int it = 0; it < 300; it++) begin
            int op = $urandom % 4;
            if (op < 2) send(29'($urandom), 1'($urandom), 1'($urandom % 4 == 0),
                             4'($urandom % 9), {$urandom, $urandom});
            else if (op == 2) xfer(1 + ($urandom % 16), 8'($urandom) & 8'h7B, "R7 random read");
            else release_obj($urandom % 16);
        end
        hr(4'd11, d);
        check("R3 pending via host", d, m_pend());

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule